// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block holds the programming state of an interrupt router behind a two-register indirect bus window. Software writes an 8-bit index into a select register, then reads or writes a 32-bit data window to reach the register that the index names. Behind the window are a version word, a 4-bit router ID (visible through two indices), and one 64-bit redirection entry per input pin, split into a lower and an upper 32-bit half.

The entries are exposed as a flat vector to the delivery logic next to this block. That logic owns two status bits in every entry: the delivery-status bit and the remote-pending bit. It sets remote-pending with a per-pin pulse, clears it on end-of-interrupt, and drives delivery status from a busy signal. Software writes never alter these two bits. The one exception is that an entry left in edge mode by a write has its remote-pending bit cleared. After a write leaves an entry in level mode while its pin is requesting, the block pulses a per-pin service request so that the pending level can be delivered again.

The bus side is a simple strobe interface. Writes take effect at the clock edge. Read data and a valid flag appear one cycle after the read strobe.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, the select register and the router ID are 0. Every entry reads 0x0001_0000 in its lower half (mask, bit 16, set) and 0 in its upper half.
- R2: A write at offset 0x00 stores only bits 7:0 of the data in the select register. A read at offset 0x00 returns the select value zero-extended to 32 bits.
- R3: With select = 0x01, a window read returns pin count minus one in bits 23:16 and the version code in bits 7:0, with all other bits 0. A window write at this index changes nothing.
- R4: With select = 0x00, a window write loads data bits 27:24 into the ID. A window read at index 0x00 or 0x02 returns the ID in bits 27:24 and 0 elsewhere. A window write at index 0x02 changes nothing.
- R5: A select value of 0x10 or above addresses entry (select − 0x10) >> 1. An even select reaches bits 31:0 of that entry and an odd select reaches bits 63:32.
- R6: A select that names an entry at or beyond the pin count, or any value from 0x03 to 0x0F, reads as 0xFFFF_FFFF, and a window write at that select modifies no entry.
- R7: A window write to either half of an entry leaves bit 12 (delivery status) and bit 14 (remote pending) at their values from before the write.
- R8: If an entry write leaves bit 15 (trigger mode, 1 = level) at 0, bit 14 of that entry is 0 after the write.
- R9: In the cycle after a window write to entry n that leaves bit 15 at 1 while pin_req[n] is 1, svc_req[n] is 1. No other write produces svc_req.
- R10: A read at any offset other than 0x00 and 0x10 returns 0, and a write at any such offset changes no state.
- R11: A pulse on set_remote[n] sets bit 14 of entry n, and a pulse on eoi_clr[n] clears it. Bit 12 of entry n follows dlv_busy[n] with a one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_rd |
| pin_req | input | NUM_PINS | Current request level per pin |
| set_remote | input | NUM_PINS | Delivery logic sets remote pending |
| eoi_clr | input | NUM_PINS | End-of-interrupt clears remote pending |
| dlv_busy | input | NUM_PINS | Delivery in progress per pin |
| svc_req | output | NUM_PINS | Service attempt pulse per pin |
| entry_flat | output | 64*NUM_PINS | All entries, entry n in bits 64n+63:64n |

## Verification
The bench builds the block with NUM_PINS = 4 and version code 0x11. With four pins, the out-of-range entry boundary sits at select 0x18, so a handful of window accesses can test the first unimplemented entry and the gap between the ID indices and the table. The small pin count also lets the bench watch the whole entry_flat vector to confirm that a dropped write touches no entry. Each hardware-owned status bit is driven on one pin while writes with every combination of trigger mode are issued to it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ENT_W  = 64;
  localparam int B_DLV  = 12;
  localparam int B_REM  = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;

  // Reset value of one redirection entry: only the mask bit set.
  function automatic logic [ENT_W-1:0] entry_reset();
    logic [ENT_W-1:0] e;
    e = '0;
    e[B_MASK] = 1'b1;
    return e;
  endfunction

  // Merge one 32-bit half into an entry while keeping hardware-owned bits.
  function automatic logic [ENT_W-1:0] merge_half(input logic [ENT_W-1:0] old,
                                                  input logic [31:0] d,
                                                  input logic hi);
    logic [ENT_W-1:0] n;
    n = old;
    if (hi) n[63:32] = d;
    else    n[31:0]  = d;
    n[B_DLV] = old[B_DLV];
    n[B_REM] = old[B_REM];
    if (!n[B_TRIG]) n[B_REM] = 1'b0;
    return n;
  endfunction

  function automatic logic [31:0] version_word(input int pins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(pins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] SEL_OFF = 8'h00,
  parameter logic [7:0] WIN_OFF = 8'h10,
  parameter logic [7:0] ID_IDX  = 8'h00,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [7:0]        sel_q,
  output logic              win_wr,
  output logic              id_wr,
  output logic              ent_ok,
  output logic              ent_hi,
  output logic [IDX_W-1:0]  ent_idx,
  output logic [NUM_PINS-1:0] ent_wr
);
  logic [6:0] raw_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 8'h00;
    else if (bus_wr && bus_addr == SEL_OFF) sel_q <= bus_wdata[7:0];
  end

  always_comb begin
    raw_idx = 7'((sel_q - 8'h10) >> 1);
    ent_ok  = (sel_q >= 8'h10) && (int'(raw_idx) < NUM_PINS);
    ent_hi  = sel_q[0];
    ent_idx = IDX_W'(raw_idx);
    win_wr  = bus_wr && (bus_addr == WIN_OFF);
    id_wr   = win_wr && (sel_q == ID_IDX);
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_wr
    assign ent_wr[g] = win_wr && ent_ok && (int'(ent_idx) == g);
  end
endmodule

// File: rtl/irq_entry_slot.sv
module irq_entry_slot
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              hi,
  input  logic [31:0]       wdata,
  input  logic              set_remote,
  input  logic              eoi_clr,
  input  logic              dlv_busy,
  input  logic              pin_req,
  output logic [ENT_W-1:0]  ent,
  output logic              svc
);
  logic [ENT_W-1:0] base, nxt;

  always_comb begin
    base = ent;
    base[B_DLV] = dlv_busy;
    base[B_REM] = (ent[B_REM] | set_remote) & ~eoi_clr;
    nxt = wr ? merge_half(base, wdata, hi) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= entry_reset();
      svc <= 1'b0;
    end else begin
      ent <= nxt;
      svc <= wr && nxt[B_TRIG] && pin_req;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] SEL_OFF = 8'h00,
  parameter logic [7:0] WIN_OFF = 8'h10,
  parameter logic [7:0] ID_IDX  = 8'h00,
  parameter logic [7:0] VER_IDX = 8'h01,
  parameter logic [7:0] ARB_IDX = 8'h02,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter int IDX_W = 5
) (
  input  logic [7:0]              bus_addr,
  input  logic [7:0]              sel_q,
  input  logic [3:0]              id_q,
  input  logic                    ent_ok,
  input  logic                    ent_hi,
  input  logic [IDX_W-1:0]        ent_idx,
  input  logic [ENT_W*NUM_PINS-1:0] entry_flat,
  output logic [31:0]             rdata
);
  logic [ENT_W-1:0] pick;

  always_comb begin
    pick = '1;
    for (int i = 0; i < NUM_PINS; i++)
      if (int'(ent_idx) == i) pick = entry_flat[i*ENT_W +: ENT_W];
  end

  always_comb begin
    if (bus_addr == SEL_OFF) rdata = {24'h0, sel_q};
    else if (bus_addr == WIN_OFF) begin
      if (sel_q == VER_IDX) rdata = version_word(NUM_PINS, VER_CODE);
      else if (sel_q == ID_IDX || sel_q == ARB_IDX) rdata = {4'h0, id_q, 24'h0};
      else if (ent_ok) rdata = ent_hi ? pick[63:32] : pick[31:0];
      else rdata = 32'hFFFF_FFFF;
    end else rdata = 32'h0;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [7:0]                bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_rvalid,
  input  logic [NUM_PINS-1:0]       pin_req,
  input  logic [NUM_PINS-1:0]       set_remote,
  input  logic [NUM_PINS-1:0]       eoi_clr,
  input  logic [NUM_PINS-1:0]       dlv_busy,
  output logic [NUM_PINS-1:0]       svc_req,
  output logic [64*NUM_PINS-1:0]    entry_flat
);
  localparam logic [7:0] SEL_OFF = 8'h00;
  localparam logic [7:0] WIN_OFF = 8'h10;
  localparam logic [7:0] ID_IDX  = 8'h00;
  localparam logic [7:0] VER_IDX = 8'h01;
  localparam logic [7:0] ARB_IDX = 8'h02;

  // Named internal events, also used by the bound checker.
  logic [7:0]          sel_q;
  logic                win_wr, id_wr, ent_ok, ent_hi;
  logic [IDX_W-1:0]    ent_idx;
  logic [NUM_PINS-1:0] ent_wr;
  logic [3:0]          id_q;
  logic [31:0]         rd_comb;

  irq_reg_decode #(.NUM_PINS(NUM_PINS), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF),
                   .ID_IDX(ID_IDX), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sel_q(sel_q), .win_wr(win_wr), .id_wr(id_wr),
    .ent_ok(ent_ok), .ent_hi(ent_hi), .ent_idx(ent_idx), .ent_wr(ent_wr)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
    irq_entry_slot u_slot (
      .clk(clk), .rst_n(rst_n), .wr(ent_wr[g]), .hi(ent_hi), .wdata(bus_wdata),
      .set_remote(set_remote[g]), .eoi_clr(eoi_clr[g]), .dlv_busy(dlv_busy[g]),
      .pin_req(pin_req[g]), .ent(entry_flat[g*ENT_W +: ENT_W]), .svc(svc_req[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= 4'h0;
    else if (id_wr) id_q <= bus_wdata[27:24];
  end

  irq_read_mux #(.NUM_PINS(NUM_PINS), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF),
                 .ID_IDX(ID_IDX), .VER_IDX(VER_IDX), .ARB_IDX(ARB_IDX),
                 .VER_CODE(VER_CODE), .IDX_W(IDX_W)) u_rmux (
    .bus_addr(bus_addr), .sel_q(sel_q), .id_q(id_q), .ent_ok(ent_ok),
    .ent_hi(ent_hi), .ent_idx(ent_idx), .entry_flat(entry_flat), .rdata(rd_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'h0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_comb;
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             sel_q,
  input logic                   win_wr,
  input logic [NUM_PINS-1:0]    ent_wr,
  input logic [NUM_PINS-1:0]    svc_req,
  input logic [NUM_PINS-1:0]    set_remote,
  input logic [NUM_PINS-1:0]    eoi_clr,
  input logic [64*NUM_PINS-1:0] entry_flat
);
  localparam int OOR_SEL = 16 + 2 * NUM_PINS;

  // R5: at most one entry is written per access
  a_r5_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_wr));

  // R6: unimplemented selects write no entry
  a_r6_oor_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && (int'(sel_q) >= OOR_SEL || (sel_q >= 8'h03 && sel_q < 8'h10)))
      |-> (ent_wr == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R8: edge-mode result has remote pending cleared
    a_r8_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ent_wr[i] |=> (entry_flat[i*64+15] || !entry_flat[i*64+14]));
    // R7: a write alone never raises remote pending
    a_r7_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_wr[i] && !set_remote[i] && !entry_flat[i*64+14]) |=> !entry_flat[i*64+14]);
    // R9: service pulse only after a write to that entry
    a_r9_svc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req[i] |-> $past(ent_wr[i]));
    // R11: set pulse raises remote pending
    a_r11_remote_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_remote[i] && !eoi_clr[i] && !ent_wr[i]) |=> entry_flat[i*64+14]);
  end
endmodule

bind irq_route_regs irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .win_wr(win_wr), .ent_wr(ent_wr),
  .svc_req(svc_req), .set_remote(set_remote), .eoi_clr(eoi_clr),
  .entry_flat(entry_flat)
);

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NP-1:0] pin_req = '0, set_remote = '0, eoi_clr = '0, dlv_busy = '0;
  logic [NP-1:0] svc_req;
  logic [64*NP-1:0] entry_flat;
  logic [64*NP-1:0] snap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_regs #(.NUM_PINS(NP), .VER_CODE(8'h11)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_req(pin_req), .set_remote(set_remote),
    .eoi_clr(eoi_clr), .dlv_busy(dlv_busy), .svc_req(svc_req),
    .entry_flat(entry_flat)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected word to the scoreboard.
  task automatic bread(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wsel(input logic [7:0] s);
    bwrite(8'h00, {24'h0, s});
  endtask

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        check({32'h0, bus_rdata}, {32'h0, exp_q.pop_front()}, tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bread(8'h00, 32'h0, "R1 select reset");
    bread(8'h10, 32'h0, "R1 id reset");
    wsel(8'h16);
    bread(8'h10, 32'h0001_0000, "R1 entry3 low reset");
    wsel(8'h17);
    bread(8'h10, 32'h0, "R1 entry3 high reset");

    bwrite(8'h00, 32'h1234_5613);
    bread(8'h00, 32'h0000_0013, "R2 select low byte");

    wsel(8'h01);
    bread(8'h10, 32'h0003_0011, "R3 version");
    bwrite(8'h10, 32'hFFFF_FFFF);
    bread(8'h10, 32'h0003_0011, "R3 version write ignored");

    wsel(8'h00);
    bwrite(8'h10, 32'hA500_0000);
    bread(8'h10, 32'h0500_0000, "R4 id load");
    wsel(8'h02);
    bread(8'h10, 32'h0500_0000, "R4 arb index reads id");
    bwrite(8'h10, 32'h0F00_0000);
    bread(8'h10, 32'h0500_0000, "R4 arb write ignored");

    wsel(8'h14);
    bwrite(8'h10, 32'h0000_A0C5);
    bread(8'h10, 32'h0000_A0C5, "R5 entry2 low");
    wsel(8'h15);
    bwrite(8'h10, 32'hAB00_0000);
    bread(8'h10, 32'hAB00_0000, "R5 entry2 high");
    wsel(8'h14);
    bread(8'h10, 32'h0000_A0C5, "R5 entry2 low kept");
    check(entry_flat[2*64 +: 64], 64'hAB00_0000_0000_A0C5, "R5 entry2 exposed");

    bwrite(8'h10, 32'h0000_F0C5);
    bread(8'h10, 32'h0000_A0C5, "R7 status bits not writable");

    dlv_busy[2] = 1'b1;
    @(negedge clk); set_remote[2] = 1'b1;
    @(negedge clk); set_remote[2] = 1'b0;
    bread(8'h10, 32'h0000_F0C5, "R11 remote set and busy");
    bwrite(8'h10, 32'h0000_A0C5);
    bread(8'h10, 32'h0000_F0C5, "R7 status kept on level write");
    bwrite(8'h10, 32'h0000_20C5);
    bread(8'h10, 32'h0000_30C5, "R8 edge write clears remote");
    dlv_busy[2] = 1'b0;
    bread(8'h10, 32'h0000_20C5, "R11 busy follows");
    bwrite(8'h10, 32'h0000_A0C5);
    @(negedge clk); set_remote[2] = 1'b1;
    @(negedge clk); set_remote[2] = 1'b0; eoi_clr[2] = 1'b1;
    @(negedge clk); eoi_clr[2] = 1'b0;
    bread(8'h10, 32'h0000_A0C5, "R11 eoi clears remote");

    pin_req[1] = 1'b1;
    wsel(8'h12);
    bwrite(8'h10, 32'h0000_8041);
    check({60'h0, svc_req}, 64'h2, "R9 level write requests service");
    @(negedge clk);
    check({60'h0, svc_req}, 64'h0, "R9 pulse one cycle");
    bwrite(8'h10, 32'h0000_0041);
    check({60'h0, svc_req}, 64'h0, "R9 edge write no service");
    pin_req[1] = 1'b0;
    bwrite(8'h10, 32'h0000_8041);
    check({60'h0, svc_req}, 64'h0, "R9 no request no service");

    wsel(8'h18);
    bread(8'h10, 32'hFFFF_FFFF, "R6 entry beyond pins");
    snap = entry_flat;
    bwrite(8'h10, 32'h1234_5678);
    @(negedge clk);
    check(entry_flat[127:0] ^ snap[127:0], 128'h0, "R6 dropped write lo");
    check(entry_flat[255:128] ^ snap[255:128], 128'h0, "R6 dropped write hi");
    wsel(8'h05);
    bread(8'h10, 32'hFFFF_FFFF, "R6 gap index");
    snap = entry_flat;
    bwrite(8'h10, 32'h0000_0000);
    @(negedge clk);
    check({63'h0, entry_flat == snap}, 64'h1, "R6 gap write dropped");

    bread(8'h20, 32'h0, "R10 other offset reads 0");
    bread(8'h04, 32'h0, "R10 offset 4 reads 0");
    snap = entry_flat;
    bwrite(8'h20, 32'h0000_00FF);
    bwrite(8'h04, 32'h0000_0016);
    bread(8'h00, 32'h0000_0005, "R10 select untouched");
    check({63'h0, entry_flat == snap}, 64'h1, "R10 entries untouched");

    repeat (2) @(negedge clk);
    check(64'(exp_q.size()), 64'h0, "scoreboard drained");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule